// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block is the host side of a three-wire link to a serial analog-to-digital converter. The three wires are an active-low chip select, an I/O clock and a serial data return. When the block is idle and a start request arrives, it pulls chip select low. It then issues a burst of I/O clock pulses whose count is configured between 10 and 16. The system clock is divided down to make the I/O clock, which has a 50% duty cycle. The data line is sampled on each rising edge of the I/O clock for the first ten pulses, most significant bit first. The ten captured bits are presented as a parallel word with a one-cycle valid strobe.

The converter returns the result of the conversion that the previous transfer started. For that reason the first result after reset is marked stale. After the burst, chip select is released unless hold-low mode is selected. A programmable wait then gives the converter time to finish converting. The busy output stays high for the whole transfer and for the wait. Start requests that arrive while busy have no effect.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, busy_o is 0, valid_o is 0, stale_o is 0 and result_o is 0.
- R2: A start_i sampled high while busy_o is low drives cs_no low and busy_o high in the next cycle. busy_o can rise only in response to such a start.
- R3: The burst contains exactly clamp(burst_len_i, 10, 16) rising edges of sclk_o. burst_len_i is latched at start.
- R4: Each sclk_o high phase and each low phase lasts D system cycles. D is div_i, or 1 when div_i is 0. sclk_o is therefore high for D times the pulse count cycles per transfer.
- R5: sdata_i is sampled at the system edge where sclk_o rises, for the first ten pulses only. The first sample lands in result_o[9] and the tenth in result_o[0]. Data on later pulses is discarded.
- R6: valid_o pulses high for exactly one cycle per transfer, while busy_o is high. result_o changes only together with that pulse.
- R7: stale_o is high together with the first valid_o after reset and low for every later one.
- R8: After the burst, cs_no returns to 1 if hold_cs_i was 0 at start. It stays 0 if hold_cs_i was 1. While idle with hold_cs_i low, cs_no is 1.
- R9: busy_o stays high for D + 2·D·L + W + 1 cycles, where L is the clamped pulse count and W is wait_i latched at the end of the burst.
- R10: A start_i pulse while busy_o is high neither changes the current transfer nor starts another one.
- R11: sclk_o is never high while cs_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one transfer |
| burst_len_i | input | LEN_W (5) | I/O clock pulses per transfer, clamped to 10..16 |
| div_i | input | DIV_W (4) | I/O clock half-period in system cycles (0 is treated as 1) |
| wait_i | input | WAIT_W (8) | Post-burst hold-off, W+1 cycles |
| hold_cs_i | input | 1 | 1: keep chip select low between transfers |
| sdata_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Active-low chip select |
| sclk_o | output | 1 | I/O clock to the converter |
| busy_o | output | 1 | Transfer or hold-off in progress |
| result_o | output | 10 | Last captured conversion word |
| valid_o | output | 1 | One-cycle strobe for result_o |
| stale_o | output | 1 | Marks the first result after reset as not a real conversion |

## Verification
The checker assumes that start_i, burst_len_i and the other configuration inputs are synchronous to clk_i. It also assumes that burst_len_i is steady in the cycle a start is accepted, because it latches its own copy of the clamped length at that moment. The bench keeps within these assumptions: it changes every input only at falling system edges and holds the configuration steady through each transfer. The converter model in the bench drives sdata_i from a counter of sclk_o rises that it updates at falling edges. Each bit is therefore stable well before the rising edge that samples it, and every pulse past the tenth drives a 1, so that any captured extra bit would corrupt the word.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int unsigned RES_W      = 10;
  localparam int unsigned MIN_PULSES = 10;
  localparam int unsigned MAX_PULSES = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HI,
    ST_LO,
    ST_WAIT
  } st_e;
endpackage

// File: rtl/adc_rd_cfg.sv
module adc_rd_cfg #(
  parameter int unsigned LEN_W   = 5,
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned MIN_LEN = 10,
  parameter int unsigned MAX_LEN = 16
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [LEN_W-1:0] len_o,
  output logic [DIV_W-1:0] div_o
);
  localparam logic [LEN_W-1:0] LO_LIM = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] HI_LIM = LEN_W'(MAX_LEN);

  always_comb begin
    if (len_i < LO_LIM)      len_o = LO_LIM;
    else if (len_i > HI_LIM) len_o = HI_LIM;
    else                     len_o = len_i;
    div_o = (div_i == '0) ? DIV_W'(1) : div_i;
  end
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             sample_i,
  input  logic             bit_i,
  output logic [RES_W-1:0] word_o
);
  localparam int unsigned IDX_W = $clog2(RES_W + 1);
  localparam logic [IDX_W-1:0] FULL = IDX_W'(RES_W);

  logic [IDX_W-1:0] taken_q;
  logic [RES_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= '0;
      word_q  <= '0;
    end else if (clr_i) begin
      taken_q <= '0;
    end else if (sample_i && taken_q != FULL) begin
      // MSB arrives first, extra pulses ignored
      word_q  <= {word_q[RES_W-2:0], bit_i};
      taken_q <= taken_q + 1'b1;
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned LEN_W  = 5,
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  burst_len_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              hold_cs_i,
  input  logic              sdata_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              busy_o,
  output logic [RES_W-1:0]  result_o,
  output logic              valid_o,
  output logic              stale_o
);
  localparam int unsigned CNT_W = (DIV_W > WAIT_W) ? DIV_W : WAIT_W;

  st_e               st_q, st_d;
  logic [LEN_W-1:0]  len_eff, len_q, pulses_q;
  logic [DIV_W-1:0]  div_eff, div_q;
  logic              hold_q, seen_q, cs_q, sclk_q;
  logic [RES_W-1:0]  word, result_q;
  logic              valid_q, stale_q;
  logic              accept, ld, smp, done, tz;
  logic [CNT_W-1:0]  ld_val;

  adc_rd_cfg #(
    .LEN_W(LEN_W), .DIV_W(DIV_W),
    .MIN_LEN(MIN_PULSES), .MAX_LEN(MAX_PULSES)
  ) u_cfg (
    .len_i(burst_len_i), .div_i(div_i),
    .len_o(len_eff),     .div_o(div_eff)
  );

  adc_rd_timer #(.W(CNT_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(ld), .val_i(ld_val), .zero_o(tz)
  );

  adc_rd_shift #(.RES_W(RES_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(accept), .sample_i(smp), .bit_i(sdata_i),
    .word_o(word)
  );

  assign accept = (st_q == ST_IDLE) && start_i;

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    smp    = 1'b0;
    done   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_SETUP;
        ld     = 1'b1;
        ld_val = CNT_W'(div_eff - 1'b1);
      end
      ST_SETUP: if (tz) begin
        st_d   = ST_HI;
        ld     = 1'b1;
        ld_val = CNT_W'(div_q - 1'b1);
        smp    = 1'b1;
      end
      ST_HI: if (tz) begin
        st_d   = ST_LO;
        ld     = 1'b1;
        ld_val = CNT_W'(div_q - 1'b1);
      end
      ST_LO: if (tz) begin
        ld = 1'b1;
        if (pulses_q == len_q) begin
          st_d   = ST_WAIT;
          ld_val = CNT_W'(wait_i);
          done   = 1'b1;
        end else begin
          st_d   = ST_HI;
          ld_val = CNT_W'(div_q - 1'b1);
          smp    = 1'b1;
        end
      end
      ST_WAIT: if (tz) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      len_q    <= LEN_W'(MIN_PULSES);
      div_q    <= DIV_W'(1);
      pulses_q <= '0;
      hold_q   <= 1'b0;
      seen_q   <= 1'b0;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b0;
      result_q <= '0;
      valid_q  <= 1'b0;
      stale_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      sclk_q  <= (st_d == ST_HI);
      valid_q <= done;
      stale_q <= done && !seen_q;
      if (accept) begin
        len_q    <= len_eff;
        div_q    <= div_eff;
        hold_q   <= hold_cs_i;
        pulses_q <= '0;
        cs_q     <= 1'b0;
      end else if (done) begin
        cs_q <= !hold_q;
      end else if (st_q == ST_IDLE && !hold_cs_i) begin
        cs_q <= 1'b1;
      end
      if (st_q == ST_HI && tz) pulses_q <= pulses_q + 1'b1;
      if (done) begin
        result_q <= word;
        seen_q   <= 1'b1;
      end
    end
  end

  assign cs_no    = cs_q;
  assign sclk_o   = sclk_q;
  assign busy_o   = (st_q != ST_IDLE);
  assign result_o = result_q;
  assign valid_o  = valid_q;
  assign stale_o  = stale_q;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int unsigned LEN_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [LEN_W-1:0] burst_len_i,
  input logic             cs_no,
  input logic             sclk_o,
  input logic             busy_o,
  input logic             valid_o,
  input logic             stale_o
);
  logic [LEN_W:0] exp_q, rises_q;
  logic           sclk_d;

  function automatic logic [LEN_W:0] clamp_len(input logic [LEN_W-1:0] v);
    if (v < LEN_W'(10))      return (LEN_W+1)'(10);
    else if (v > LEN_W'(16)) return (LEN_W+1)'(16);
    else                     return {1'b0, v};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q   <= '0;
      rises_q <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_d <= sclk_o;
      if (start_i && !busy_o) begin
        exp_q   <= clamp_len(burst_len_i);
        rises_q <= '0;
      end else if (sclk_o && !sclk_d) begin
        rises_q <= rises_q + 1'b1;
      end
    end
  end

  // R11
  cs_gates_sclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  // R3
  pulse_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> rises_q == exp_q);
  // R6
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R6
  valid_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> busy_o);
  // R7
  stale_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stale_o |-> valid_o);
  // R2
  cs_fall_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(start_i && !busy_o));
  // R10
  busy_rise_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .burst_len_i(burst_len_i), .cs_no(cs_no), .sclk_o(sclk_o),
  .busy_o(busy_o), .valid_o(valid_o), .stale_o(stale_o)
);

// File: tb/tb_adc_rd_ctrl.sv
module tb_adc_rd_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [4:0] burst_len_i = '0;
  logic [3:0] div_i = '0;
  logic [7:0] wait_i = '0;
  logic       hold_cs_i = 1'b0;
  logic       sdata_i;
  logic       cs_no, sclk_o, busy_o, valid_o, stale_o;
  logic [9:0] result_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [9:0] tx_word = '0;
  int nbit = 0;
  logic sclk_prev = 1'b0;
  logic [9:0] prev_samp;
  int xfer_idx = 0;

  always #4 clk_i = ~clk_i;

  adc_rd_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .burst_len_i(burst_len_i), .div_i(div_i), .wait_i(wait_i),
    .hold_cs_i(hold_cs_i), .sdata_i(sdata_i), .cs_no(cs_no),
    .sclk_o(sclk_o), .busy_o(busy_o), .result_o(result_o),
    .valid_o(valid_o), .stale_o(stale_o)
  );

  // converter model: bit k valid before k-th rising sclk, extra bits are 1
  assign sdata_i = (nbit < 10) ? tx_word[9 - nbit] : 1'b1;

  always @(negedge clk_i) begin
    if (sclk_o && !sclk_prev) nbit <= nbit + 1;
    sclk_prev <= sclk_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    start_i = 1'b0;
    hold_cs_i = 1'b0;
    repeat (2) @(negedge clk_i);
    // R1
    chk("R1 cs_no", cs_no, 1);
    chk("R1 sclk_o", sclk_o, 0);
    chk("R1 busy_o", busy_o, 0);
    chk("R1 valid_o", valid_o, 0);
    chk("R1 stale_o", stale_o, 0);
    chk("R1 result_o", result_o, 0);
    rst_ni = 1'b1;
    xfer_idx = 0;
    @(negedge clk_i);
  endtask

  task automatic xfer(input int len, input int dv, input int hold, input int w,
                      input bit inject);
    int le, de, busy_n, rises, hi_n, vcnt, res, stl, guard;
    logic [9:0] samp;
    le = (len < 10) ? 10 : (len > 16) ? 16 : len;
    de = (dv == 0) ? 1 : dv;
    samp = 10'((xfer_idx * 37 + 5) * 13);
    burst_len_i = 5'(len);
    div_i = 4'(dv);
    wait_i = 8'(w);
    hold_cs_i = hold[0];
    tx_word = (xfer_idx == 0) ? 10'h2A5 : prev_samp;
    nbit = 0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R2
    chk("R2 busy rises", busy_o, 1);
    chk("R2 cs low", cs_no, 0);
    busy_n = 0; rises = 0; hi_n = 0; vcnt = 0; res = -1; stl = -1; guard = 0;
    while (busy_o && guard < 5000) begin
      busy_n++;
      if (sclk_o) hi_n++;
      if (sclk_o && !sclk_prev) rises++;
      if (valid_o) begin vcnt++; res = int'(result_o); stl = int'(stale_o); end
      start_i = inject && (busy_n == 4);
      guard++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk("R3 pulse count", rises, le);
    chk("R4 high cycles", hi_n, de * le);
    chk("R5 result word", res, int'(tx_word));
    chk("R6 valid pulses", vcnt, 1);
    chk("R7 stale flag", stl, (xfer_idx == 0) ? 1 : 0);
    chk("R9 busy length", busy_n, de + 2 * de * le + w + 1);
    chk("R8 cs after burst", cs_no, hold ? 0 : 1);
    if (inject) begin
      repeat (3) @(negedge clk_i);
      // R10
      chk("R10 no extra transfer", busy_o, 0);
    end
    prev_samp = samp;
    xfer_idx++;
  endtask

  initial begin
    do_reset();
    for (int h = 0; h < 2; h++)
      for (int d = 0; d < 4; d++)
        for (int l = 8; l <= 18; l++)
          xfer(l, d, h, (l * 3 + d) % 7, (l % 4) == 1);
    xfer(31, 2, 0, 20, 1'b1);
    xfer(0, 1, 1, 0, 1'b0);
    // R8 idle with hold released drives cs high
    hold_cs_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R8 idle cs high", cs_no, 1);
    do_reset();
    xfer(12, 3, 0, 2, 1'b0);
    xfer(16, 1, 0, 0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule